// File: doc/BRIEF.md
# Single-Flag Carry/Overflow ALU Slice

This block is the arithmetic and rotate portion of a small integer datapath. One status bit, called T here, carries four roles. It is the carry into and out of additions, the borrow through subtractions and negation, the overflow indication for the checked add and subtract, and the extra bit that rotates pass through. Two operands come in: A is the source and B is the destination word. A 3-bit code selects the operation. The result word and the next value of T are produced combinationally from the operands and the stored T.

T lives in a register inside the block. It takes the computed next value on a clock edge when the operation strobe is high. A separate load input forces it to a given bit and takes priority over the strobe. A synchronous active-high reset clears it. Decode, register storage and the remaining status bits belong to the surrounding pipeline.

Top module: `tflag_alu`

## Requirements
- R1: Code 0 (add with carry) gives result = B + A + T modulo 2^32. Next T is 1 when either the first sum B + A or the addition of T to it carries out of bit 31.
- R2: Code 1 (add, overflow check) gives result = B + A. Next T is 1 only when A and B have equal sign bits and the result's bit 31 differs from them; otherwise it is 0.
- R3: Code 2 (subtract with borrow) gives result = B − A − T. Next T is 1 when B − A borrows or when removing T from that difference borrows.
- R4: Code 3 (subtract, overflow check) gives result = B − A. Next T is 1 only when the sign bits of A and B differ and the result's bit 31 differs from B's bit 31; otherwise it is 0.
- R5: Code 4 (negate with borrow) gives result = 0 − A − T. Next T is 1 when A is nonzero, or when removing T from 0 − A wraps.
- R6: Code 5 (rotate left through T) gives result = {B[30:0], T}, and next T = B[31].
- R7: Code 6 (rotate right through T) gives result = {T, B[31:1]}, and next T = B[0].
- R8: Code 7 gives result = B, and next T equals the stored T.
- R9: The stored T takes the next-T value on a rising clock edge when op_valid is high. When op_valid and t_load are both low it keeps its value.
- R10: When t_load is high, the stored T takes t_load_val on the rising clock edge, whatever op_valid and the operation are.
- R11: When rst is high on a rising clock edge, the stored T becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of T |
| op_valid | input | 1 | Commit the computed next T on this edge |
| op_sel | input | 3 | Operation code, 0 to 7 |
| opnd_a | input | 32 | Source operand A |
| opnd_b | input | 32 | Destination operand B |
| t_load | input | 1 | Force T from t_load_val (priority over op_valid) |
| t_load_val | input | 1 | Value forced into T |
| result | output | 32 | Combinational result word |
| t_next | output | 1 | Combinational next value of T |
| t_flag | output | 1 | Stored T |

## Verification
The add and subtract codes are each driven with operand pairs that carry or borrow in the first step only, in the T step only, and in neither. A wrong OR of the two steps, or a dropped T term, then gives a different flag. The overflow codes get both positive and negative overflow, plus same-sign and mixed-sign pairs that must not flag, which separates the sign rules of add and subtract. Negation is tried with A zero and nonzero under both T values, and the rotates use words whose end bits differ from T so that the direction shows. A long chained run with random operands feeds each committed T into the next operation. Strobe-low, load-over-strobe and mid-run reset cases show when T moves.

// File: rtl/tflag_alu_pkg.sv
package tflag_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADDC = 3'd0,
    OP_ADDV = 3'd1,
    OP_SUBC = 3'd2,
    OP_SUBV = 3'd3,
    OP_NEGC = 3'd4,
    OP_ROTL = 3'd5,
    OP_ROTR = 3'd6,
    OP_PASS = 3'd7
  } tflag_op_e;

endpackage

// File: rtl/tflag_addsub.sv
module tflag_addsub
  import tflag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  tflag_op_e        op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             t_in,
  output logic [WIDTH-1:0] res,
  output logic             t_out,
  output logic             carry_first,
  output logic             carry_second,
  output logic             borrow_first,
  output logic             borrow_second,
  output logic             add_ovf,
  output logic             sub_ovf
);
  localparam int MSB = WIDTH - 1;

  // widened sum; top bit is the carry out
  function automatic logic [WIDTH:0] wide_add(input logic [WIDTH-1:0] x,
                                              input logic [WIDTH-1:0] y,
                                              input logic             cin);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  endfunction

  // widened difference; top bit is the borrow out
  function automatic logic [WIDTH:0] wide_sub(input logic [WIDTH-1:0] x,
                                              input logic [WIDTH-1:0] y,
                                              input logic             bin);
    return {1'b0, x} - {1'b0, y} - {{WIDTH{1'b0}}, bin};
  endfunction

  function automatic logic sum_overflows(input logic [WIDTH-1:0] x,
                                         input logic [WIDTH-1:0] y,
                                         input logic [WIDTH-1:0] s);
    return (x[MSB] == y[MSB]) && (s[MSB] != x[MSB]);
  endfunction

  function automatic logic diff_overflows(input logic [WIDTH-1:0] x,
                                          input logic [WIDTH-1:0] y,
                                          input logic [WIDTH-1:0] d);
    return (x[MSB] != y[MSB]) && (d[MSB] != x[MSB]);
  endfunction

  logic [WIDTH:0] add_s1, add_s2;
  logic [WIDTH:0] sub_s1, sub_s2;
  logic [WIDTH:0] neg_s1, neg_s2;

  // two-stage chains: operand step, then the T step
  assign add_s1 = wide_add(b, a, 1'b0);
  assign add_s2 = wide_add(add_s1[MSB:0], {WIDTH{1'b0}}, t_in);
  assign sub_s1 = wide_sub(b, a, 1'b0);
  assign sub_s2 = wide_sub(sub_s1[MSB:0], {WIDTH{1'b0}}, t_in);
  assign neg_s1 = wide_sub({WIDTH{1'b0}}, a, 1'b0);
  assign neg_s2 = wide_sub(neg_s1[MSB:0], {WIDTH{1'b0}}, t_in);

  assign carry_first   = add_s1[WIDTH];
  assign carry_second  = add_s2[WIDTH];
  assign add_ovf       = sum_overflows(b, a, add_s1[MSB:0]);
  assign sub_ovf       = diff_overflows(b, a, sub_s1[MSB:0]);

  // borrow events follow whichever subtracting chain is selected
  always_comb begin
    if (op == OP_NEGC) begin
      borrow_first  = neg_s1[WIDTH];
      borrow_second = neg_s2[WIDTH];
    end else begin
      borrow_first  = sub_s1[WIDTH];
      borrow_second = sub_s2[WIDTH];
    end
  end

  always_comb begin
    res   = add_s1[MSB:0];
    t_out = add_ovf;
    unique case (op)
      OP_ADDC: begin
        res   = add_s2[MSB:0];
        t_out = carry_first | carry_second;
      end
      OP_ADDV: begin
        res   = add_s1[MSB:0];
        t_out = add_ovf;
      end
      OP_SUBC: begin
        res   = sub_s2[MSB:0];
        t_out = borrow_first | borrow_second;
      end
      OP_SUBV: begin
        res   = sub_s1[MSB:0];
        t_out = sub_ovf;
      end
      OP_NEGC: begin
        res   = neg_s2[MSB:0];
        t_out = borrow_first | borrow_second;
      end
      default: begin
        res   = add_s1[MSB:0];
        t_out = add_ovf;
      end
    endcase
  end

endmodule

// File: rtl/tflag_rotate.sv
module tflag_rotate #(
  parameter int WIDTH = 32
) (
  input  logic             to_left,
  input  logic [WIDTH-1:0] word,
  input  logic             t_in,
  output logic [WIDTH-1:0] res,
  output logic             t_out
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH:0] rot_left(input logic [WIDTH-1:0] w,
                                              input logic             t);
    return {w, t};
  endfunction

  function automatic logic [WIDTH:0] rot_right(input logic [WIDTH-1:0] w,
                                               input logic             t);
    return {w[0], t, w[MSB:1]};
  endfunction

  logic [WIDTH:0] left_v, right_v;

  assign left_v  = rot_left(word, t_in);
  assign right_v = rot_right(word, t_in);

  assign res   = to_left ? left_v[MSB:0] : right_v[MSB:0];
  assign t_out = to_left ? left_v[WIDTH] : right_v[WIDTH];

endmodule

// File: rtl/tflag_reg.sv
module tflag_reg (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_val,
  input  logic upd,
  input  logic upd_val,
  output logic t_q
);

  always_ff @(posedge clk) begin
    if (rst)
      t_q <= 1'b0;
    else if (load)
      t_q <= load_val;
    else if (upd)
      t_q <= upd_val;
  end

endmodule

// File: rtl/tflag_alu.sv
module tflag_alu
  import tflag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             t_load,
  input  logic             t_load_val,
  output logic [WIDTH-1:0] result,
  output logic             t_next,
  output logic             t_flag
);
  localparam int MSB = WIDTH - 1;

  tflag_op_e        op_e;
  logic [WIDTH-1:0] as_res, rot_res;
  logic             as_t, rot_t;
  logic             ev_carry1, ev_carry2, ev_borrow1, ev_borrow2;
  logic             ev_add_ovf, ev_sub_ovf;
  logic             is_rot;

  assign op_e   = tflag_op_e'(op_sel);
  assign is_rot = (op_e == OP_ROTL) || (op_e == OP_ROTR);

  tflag_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op            (op_e),
    .a             (opnd_a),
    .b             (opnd_b),
    .t_in          (t_flag),
    .res           (as_res),
    .t_out         (as_t),
    .carry_first   (ev_carry1),
    .carry_second  (ev_carry2),
    .borrow_first  (ev_borrow1),
    .borrow_second (ev_borrow2),
    .add_ovf       (ev_add_ovf),
    .sub_ovf       (ev_sub_ovf)
  );

  tflag_rotate #(.WIDTH(WIDTH)) u_rotate (
    .to_left (op_e == OP_ROTL),
    .word    (opnd_b),
    .t_in    (t_flag),
    .res     (rot_res),
    .t_out   (rot_t)
  );

  always_comb begin
    if (op_e == OP_PASS) begin
      result = opnd_b;
      t_next = t_flag;
    end else if (is_rot) begin
      result = rot_res;
      t_next = rot_t;
    end else begin
      result = as_res;
      t_next = as_t;
    end
  end

  tflag_reg u_treg (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_load_val),
    .upd      (op_valid),
    .upd_val  (t_next),
    .t_q      (t_flag)
  );

  // both carry steps of one addition can never fire together
  a_r1_single_carry: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_ADDC) |-> !(ev_carry1 && ev_carry2));

  a_r2_overflow_signs: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_ADDV && t_next) |->
      (opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_b[MSB]));

  a_r3_single_borrow: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_SUBC) |-> !(ev_borrow1 && ev_borrow2));

  a_r4_overflow_signs: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_SUBV && t_next) |->
      (opnd_a[MSB] != opnd_b[MSB]) && (result[MSB] != opnd_b[MSB]));

  a_r5_neg_zero: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_NEGC && opnd_a == '0) |-> (t_next == t_flag));

  a_r6_rotl_ends: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_ROTL) |-> (result[0] == t_flag) && (t_next == opnd_b[MSB]));

  a_r7_rotr_ends: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_ROTR) |-> (result[MSB] == t_flag) && (t_next == opnd_b[0]));

  a_r8_pass: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_PASS) |-> (result == opnd_b) && (t_next == t_flag));

  a_r9_commit: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !t_load) |=> (t_flag == $past(t_next)));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !t_load) |=> $stable(t_flag));

  a_r10_load: assert property (@(posedge clk) disable iff (rst)
    t_load |=> (t_flag == $past(t_load_val)));

  a_r11_reset: assert property (@(posedge clk)
    rst |=> (t_flag == 1'b0));

endmodule

// File: tb/tb_tflag_alu.sv
module tb_tflag_alu;

  typedef struct {
    logic [31:0] exp_r;
    logic        exp_t;
    logic        exp_tq;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = 3'd7;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        t_load = 1'b0;
  logic        t_load_val = 1'b0;
  logic [31:0] result;
  logic        t_next;
  logic        t_flag;

  int checks = 0;
  int errors = 0;
  logic model_t = 1'b0;
  sb_item_t sbq[$];
  event drv_ev;

  always #4 clk = ~clk;

  tflag_alu dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .t_load(t_load),
    .t_load_val(t_load_val), .result(result), .t_next(t_next),
    .t_flag(t_flag)
  );

  // reference, stated from the requirements using 33-bit and signed math
  task automatic model(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic t,
                       output logic [31:0] r, output logic tn);
    logic [32:0] w;
    longint      s;
    case (op)
      3'd0: begin w = {1'b0, b} + {1'b0, a} + 33'(t); r = w[31:0]; tn = w[32]; end
      3'd1: begin
        s  = longint'($signed(b)) + longint'($signed(a));
        r  = b + a;
        tn = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      3'd2: begin w = {1'b0, b} - {1'b0, a} - 33'(t); r = w[31:0]; tn = w[32]; end
      3'd3: begin
        s  = longint'($signed(b)) - longint'($signed(a));
        r  = b - a;
        tn = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      3'd4: begin w = 33'd0 - {1'b0, a} - 33'(t); r = w[31:0]; tn = w[32]; end
      3'd5: begin r = (b << 1) | 32'(t); tn = b[31]; end
      3'd6: begin r = (b >> 1) | {t, 31'd0}; tn = b[0]; end
      default: begin r = b; tn = t; end
    endcase
  endtask

  task automatic check1(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // driver: applies one operation and queues what the monitor must see
  task automatic apply(input string tag, input logic [2:0] op,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic valid, input logic load, input logic lval);
    sb_item_t it;
    logic [31:0] r;
    logic tn;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    op_valid = valid; t_load = load; t_load_val = lval;
    model(op, a, b, model_t, r, tn);
    it.exp_r = r; it.exp_t = tn; it.exp_tq = model_t; it.tag = tag;
    sbq.push_back(it);
    ->drv_ev;
    if (load) model_t = lval;
    else if (valid) model_t = tn;
  endtask

  task automatic set_t(input logic v);
    apply("R10", 3'd7, 32'd0, 32'd0, 1'b0, 1'b1, v);
  endtask

  // monitor: pops expectations and compares after inputs settle
  initial begin
    forever begin
      @(drv_ev);
      #1;
      if (sbq.size() > 0) begin
        sb_item_t it;
        it = sbq.pop_front();
        check1(it.tag, "result", result, it.exp_r);
        check1(it.tag, "t_next", 32'(t_next), 32'(it.exp_t));
        check1(it.tag, "t_flag", 32'(t_flag), 32'(it.exp_tq));
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1("R11", "t_flag after reset", 32'(t_flag), 32'd0);
    rst = 1'b0;

    // R1 add with carry: first-step carry, T-step carry, none
    set_t(0); apply("R1", 3'd0, 32'h1, 32'hFFFF_FFFF, 1, 0, 0);
    set_t(1); apply("R1", 3'd0, 32'h0, 32'hFFFF_FFFF, 1, 0, 0);
    set_t(1); apply("R1", 3'd0, 32'h5, 32'h7, 1, 0, 0);
    // R2 add overflow: positive, negative, mixed signs
    apply("R2", 3'd1, 32'h1, 32'h7FFF_FFFF, 1, 0, 0);
    apply("R2", 3'd1, 32'h8000_0000, 32'h8000_0000, 1, 0, 0);
    apply("R2", 3'd1, 32'h1, 32'hFFFF_FFFF, 1, 0, 0);
    // R3 subtract with borrow
    set_t(0); apply("R3", 3'd2, 32'h1, 32'h0, 1, 0, 0);
    set_t(1); apply("R3", 3'd2, 32'h5, 32'h5, 1, 0, 0);
    set_t(1); apply("R3", 3'd2, 32'h3, 32'h9, 1, 0, 0);
    // R4 subtract overflow
    apply("R4", 3'd3, 32'h1, 32'h8000_0000, 1, 0, 0);
    apply("R4", 3'd3, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1, 0, 0);
    apply("R4", 3'd3, 32'h3, 32'h5, 1, 0, 0);
    apply("R4", 3'd3, 32'hFFFF_FFFF, 32'h1, 1, 0, 0);
    // R5 negate with borrow
    set_t(0); apply("R5", 3'd4, 32'h0, 32'h0, 1, 0, 0);
    set_t(1); apply("R5", 3'd4, 32'h0, 32'h0, 1, 0, 0);
    set_t(0); apply("R5", 3'd4, 32'h5, 32'h0, 1, 0, 0);
    // R6 / R7 rotates through T
    set_t(0); apply("R6", 3'd5, 32'h0, 32'h8000_0001, 1, 0, 0);
    set_t(1); apply("R6", 3'd5, 32'h0, 32'h0, 1, 0, 0);
    set_t(0); apply("R7", 3'd6, 32'h0, 32'h8000_0001, 1, 0, 0);
    set_t(1); apply("R7", 3'd6, 32'h0, 32'h2, 1, 0, 0);
    // R8 pass-through keeps T
    set_t(1); apply("R8", 3'd7, 32'h1234, 32'hCAFE_F00D, 1, 0, 0);
    // R9 strobe low: next T would be 1 but stored T must hold at 0
    set_t(0); apply("R9", 3'd0, 32'h1, 32'hFFFF_FFFF, 0, 0, 0);
    apply("R9", 3'd7, 32'h0, 32'h0, 0, 0, 0);
    // R10 load wins over strobe: op gives T=1, load forces 0
    apply("R10", 3'd0, 32'h1, 32'hFFFF_FFFF, 1, 1, 0);
    apply("R10", 3'd7, 32'h0, 32'h0, 0, 0, 0);
    // R9 chained random run, each committed T feeds the next op
    for (int i = 0; i < 60; i++) begin
      apply("R9", 3'($urandom_range(0, 7)), $urandom, $urandom, 1, 0, 0);
    end
    // R11 reset mid-run after T forced to 1
    set_t(1);
    apply("R10", 3'd7, 32'h0, 32'h0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check1("R11", "t_flag after mid-run reset", 32'(t_flag), 32'd0);
    model_t = 1'b0;
    apply("R11", 3'd7, 32'h0, 32'h5, 0, 0, 0);
    @(negedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule